// File: doc/BRIEF.md
# Fixed-Format SHA-1 Keyed Hasher

This block computes a SHA-1 digest over one fixed-size input: a 160-bit message followed by a 128-bit key, 288 bits in all. It pads the input to a single 512-bit block on its own, so there is no length counting and no chaining of blocks. The compression runs one round per clock. When it finishes, the 160-bit digest appears at the output together with a one-cycle done pulse.

A client places a message and a key on the inputs and pulses start. Both inputs are captured in the cycle that start is accepted. From that point the engine works through its 80 rounds without further attention. Any start that arrives while a computation is in flight is dropped. The digest stays on the output until the next computation completes.

Top module: `sha1_keyed_hasher`

## Requirements
- R1: While rst_ni is low, and after it is released, done_o is 0 and digest_o is all zeros until the first computation completes.
- R2: The hashed block is, from its most significant bit downwards: msg_i[159:0], then key_i[127:0], then a single 1 bit, then 159 zero bits, then a 64-bit big-endian length field holding 288. The block is split into sixteen 32-bit words, and word 0 is the most significant.
- R3: digest_o equals the standard SHA-1 digest of that block. The state starts from 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0. Rounds 0-19 use choose, 20-39 parity, 40-59 majority and 60-79 parity, each with its standard constant. Word a sits in digest_o[159:128] and word e in digest_o[31:0].
- R4: If start_i is accepted at clock edge E, done_o is high for exactly one cycle, following edge E+81.
- R5: A start_i that arrives while a computation is running is ignored. The running computation does not restart, and only one done pulse is produced.
- R6: msg_i and key_i are sampled only at an accepted start. Changing them later does not alter the digest that results.
- R7: digest_o holds its value between done pulses, whatever the inputs do.
- R8: A start_i raised in the same cycle as done_o is accepted. It begins a new computation that completes 81 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a computation; takes effect only when idle |
| msg_i | input | 160 | Message, placed in the upper part of the block |
| key_i | input | 128 | Key, placed after the message |
| digest_o | output | 160 | Resulting digest, held until the next completion |
| done_o | output | 1 | One-cycle pulse when digest_o is updated |

## Verification
Two events can fall in the same cycle: the done pulse that ends one computation, and a start request for the next one. The bench provokes this by raising start_i on the very cycle it sees done_o high. It then checks three things: the first digest is correct, the second computation reports exactly 81 edges after that overlapping cycle, and the second digest matches its own reference. The bench also raises start_i in the middle of a run and confirms that the timing and the digest of the first run are unchanged. The reference digests come from an independent full-schedule SHA-1 model inside the bench.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int WORD_W  = 32;
  localparam int BLK_W   = 512;
  localparam int N_WORDS = BLK_W / WORD_W;
  localparam int ROUNDS  = 80;
  localparam int CNT_W   = $clog2(ROUNDS + 1);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } state_t;

  localparam state_t IV = '{a: 32'h67452301, b: 32'hEFCDAB89, c: 32'h98BADCFE,
                            d: 32'h10325476, e: 32'hC3D2E1F0};

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} phase_e;

  function automatic word_t rol(word_t x, int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/sha1_pad.sv
module sha1_pad
  import sha1_pkg::*;
#(
  parameter int MSG_W = 160,
  parameter int KEY_W = 128
) (
  input  logic [MSG_W-1:0] msg_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [BLK_W-1:0] blk_o
);
  localparam int LEN_W  = 64;
  localparam int DATA_W = MSG_W + KEY_W;
  localparam int ZERO_W = BLK_W - DATA_W - 1 - LEN_W;

  // single block only: data, marker, zero fill, length
  assign blk_o = {msg_i, key_i, 1'b1, {ZERO_W{1'b0}}, LEN_W'(DATA_W)};
endmodule

// File: rtl/sha1_sched.sv
module sha1_sched
  import sha1_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [BLK_W-1:0] blk_i,
  output word_t            w_o
);
  word_t win_q [N_WORDS];
  word_t w_new;

  // win_q[i] holds W[t+i]; the next entry is W[t+16]
  assign w_new = rol(win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0], 1);
  assign w_o   = win_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WORDS; i++) win_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < N_WORDS; i++)
        win_q[i] <= blk_i[BLK_W-1-WORD_W*i -: WORD_W];
    end else if (shift_i) begin
      for (int i = 0; i < N_WORDS-1; i++) win_q[i] <= win_q[i+1];
      win_q[N_WORDS-1] <= w_new;
    end
  end

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i)); // R5
endmodule

// File: rtl/sha1_round.sv
module sha1_round
  import sha1_pkg::*;
(
  input  state_t           st_i,
  input  word_t            w_i,
  input  logic [CNT_W-1:0] rnd_i,
  output state_t           st_o
);
  word_t f, k;

  always_comb begin
    if (rnd_i < CNT_W'(20)) begin
      f = (st_i.b & st_i.c) | (~st_i.b & st_i.d);
      k = 32'h5A827999;
    end else if (rnd_i < CNT_W'(40)) begin
      f = st_i.b ^ st_i.c ^ st_i.d;
      k = 32'h6ED9EBA1;
    end else if (rnd_i < CNT_W'(60)) begin
      f = (st_i.b & st_i.c) | (st_i.b & st_i.d) | (st_i.c & st_i.d);
      k = 32'h8F1BBCDC;
    end else begin
      f = st_i.b ^ st_i.c ^ st_i.d;
      k = 32'hCA62C1D6;
    end
    st_o.a = rol(st_i.a, 5) + f + st_i.e + k + w_i;
    st_o.b = st_i.a;
    st_o.c = rol(st_i.b, 30);
    st_o.d = st_i.c;
    st_o.e = st_i.d;
  end
endmodule

// File: rtl/sha1_keyed_hasher.sv
module sha1_keyed_hasher
  import sha1_pkg::*;
#(
  parameter int MSG_W = 160,
  parameter int KEY_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MSG_W-1:0]  msg_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic [159:0]      digest_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  state_t           st_q, st_nxt;
  logic [BLK_W-1:0] blk;
  word_t            w_cur;
  logic             accept, run;

  assign accept = (phase_q == PH_IDLE) && start_i;
  assign run    = (phase_q == PH_RUN);

  sha1_pad #(.MSG_W(MSG_W), .KEY_W(KEY_W)) u_pad (
    .msg_i (msg_i),
    .key_i (key_i),
    .blk_o (blk)
  );

  sha1_sched u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (run),
    .blk_i   (blk),
    .w_o     (w_cur)
  );

  sha1_round u_round (
    .st_i  (st_q),
    .w_i   (w_cur),
    .rnd_i (cnt_q),
    .st_o  (st_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      st_q     <= '0;
      digest_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_RUN;
          cnt_q   <= '0;
          st_q    <= IV;
        end
        PH_RUN: begin
          st_q  <= st_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) phase_q <= PH_FIN;
        end
        PH_FIN: begin
          digest_o <= {IV.a + st_q.a, IV.b + st_q.b, IV.c + st_q.c,
                       IV.d + st_q.d, IV.e + st_q.e};
          done_o   <= 1'b1;
          phase_q  <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt_q < CNT_W'(ROUNDS))); // R4
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5
  AST_DIGEST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(digest_o)); // R7
  AST_START_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (run && cnt_q == '0 && st_q == IV)); // R8
endmodule

// File: tb/sim_sha1_keyed_hasher.sv
module sim_sha1_keyed_hasher;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [159:0] msg = '0;
  logic [127:0] key = '0;
  logic [159:0] digest;
  logic         done;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  sha1_keyed_hasher u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .msg_i    (msg),
    .key_i    (key),
    .digest_o (digest),
    .done_o   (done)
  );

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // independent reference: full 80-word schedule
  function automatic logic [159:0] ref_sha(logic [159:0] m, logic [127:0] k);
    logic [511:0] b;
    logic [31:0]  w [80];
    logic [31:0]  a, bb, c, d, e, f, kk, t;
    b = {m, k, 1'b1, 159'd0, 64'd288};
    for (int i = 0; i < 16; i++) w[i] = b[511-32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = 32'h67452301; bb = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (bb & c) | (~bb & d);           kk = 32'h5A827999; end
      else if (i < 40) begin f = bb ^ c ^ d;                     kk = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (bb & c) | (bb & d) | (c & d);  kk = 32'h8F1BBCDC; end
      else             begin f = bb ^ c ^ d;                     kk = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + kk + w[i];
      e = d; d = c; c = rl(bb, 30); bb = a; a = t;
    end
    return {a + 32'h67452301, bb + 32'hEFCDAB89, c + 32'h98BADCFE,
            d + 32'h10325476, e + 32'hC3D2E1F0};
  endfunction

  task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic kick(logic [159:0] m, logic [127:0] k);
    @(negedge clk); msg = m; key = k; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // counts edges after the start edge until done; 0 if none
  task automatic wait_done(output int lat);
    lat = 0;
    for (int n = 1; n <= 120; n++) begin
      @(negedge clk);
      if (done) begin lat = n; return; end
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 done in reset", 160'(done), 160'd0);
    chk("R1 digest in reset", digest, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", 160'(done), 160'd0);
    chk("R1 digest after reset", digest, '0);
  endtask

  task automatic t_vector(logic [159:0] m, logic [127:0] k);
    int lat;
    kick(m, k);
    wait_done(lat);
    chk("R4 latency", 160'(lat), 160'd81);
    chk("R2 R3 digest", digest, ref_sha(m, k));
    @(negedge clk);
    chk("R4 single-cycle done", 160'(done), 160'd0);
  endtask

  task automatic t_busy_start();
    int lat = 0, ndone = 0, first = 0;
    logic [159:0] m1 = 160'h0123456789ABCDEF0123456789ABCDEF01234567;
    logic [127:0] k1 = 128'hFEDCBA9876543210FEDCBA9876543210;
    kick(m1, k1);
    for (int n = 1; n <= 120; n++) begin
      @(negedge clk);
      if (n == 30) begin start = 1'b1; msg = ~m1; key = ~k1; end
      if (n == 31) start = 1'b0;
      if (done) begin
        ndone++;
        if (first == 0) begin first = n; chk("R5 digest", digest, ref_sha(m1, k1)); end
      end
    end
    chk("R5 latency", 160'(first), 160'd81);
    chk("R5 one done", 160'(ndone), 160'd1);
  endtask

  task automatic t_late_inputs();
    int lat = 0;
    logic [159:0] m1 = {5{32'hA5A5_0F0F}};
    logic [127:0] k1 = {4{32'h1357_9BDF}};
    kick(m1, k1);
    msg = '1; key = '0;
    for (int n = 1; n <= 120; n++) begin
      @(negedge clk);
      if (n == 20) begin msg = 160'd1; key = 128'd2; end
      if (done && lat == 0) lat = n;
    end
    chk("R6 latency", 160'(lat), 160'd81);
    chk("R6 digest", digest, ref_sha(m1, k1));
  endtask

  task automatic t_hold();
    logic [159:0] snap = digest;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      msg = {5{32'(n * 7919)}}; key = {4{32'(n)}};
    end
    chk("R7 digest held", digest, snap);
    chk("R7 no done", 160'(done), 160'd0);
  endtask

  task automatic t_back_to_back();
    int lat;
    logic [159:0] m1 = 160'hDEADBEEF_CAFEBABE_00000000_FFFFFFFF_12345678;
    logic [127:0] k1 = 128'h80000000_00000000_00000000_00000001;
    logic [159:0] m2 = 160'h1;
    logic [127:0] k2 = 128'h0;
    kick(m1, k1);
    wait_done(lat);
    chk("R8 first latency", 160'(lat), 160'd81);
    chk("R8 first digest", digest, ref_sha(m1, k1));
    msg = m2; key = k2; start = 1'b1; // same cycle as done
    @(negedge clk); start = 1'b0;
    wait_done(lat);
    chk("R8 second latency", 160'(lat), 160'd81);
    chk("R8 second digest", digest, ref_sha(m2, k2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    summary();
  end

  initial begin
    t_reset();
    t_vector('0, '0);
    t_vector('1, '1);
    t_vector(160'h00112233_44556677_8899AABB_CCDDEEFF_01020304,
             128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0);
    t_busy_start();
    t_late_inputs();
    t_hold();
    t_back_to_back();
    summary();
  end
endmodule